// File: doc/BRIEF.md
# Block-Averaging Decimator

This block turns a stream of signed converter samples into a slow stream of block means. Each incoming sample carries a valid strobe. A single feedback accumulator adds valid samples. A free-running sample counter splits the stream into non-overlapping blocks of N = 2^LOG2_N samples. When the last sample of a block arrives, the block forms the mean by dropping the low LOG2_N bits of the sum. It presents the mean with a one-cycle valid pulse and starts the next block from zero.

With the default block of 2048 samples and a 100 kHz sample rate, the output updates about 50 times per second. The result is a plain boxcar average. It needs no delay line and no divider, which suits DC and slow-signal measurement where a long FIR would be costly.

Top module: `blk_avg_decim`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, avg_vld is 0 and avg_data is 0.
- R2: One avg_vld pulse is produced for every N valid samples accepted, and only then. The first pulse comes after exactly N valid samples following reset.
- R3: avg_data is the two's-complement block sum divided by N and rounded toward negative infinity. For example, a block whose sum is -1 gives -1.
- R4: A cycle with smp_vld low adds nothing to the sum and does not advance the block count, whatever smp_data holds.
- R5: avg_vld is high for exactly one cycle. It appears in the clock cycle after the edge that accepts the Nth valid sample of a block.
- R6: A block of full-scale samples, all at the largest positive value or all at the most negative value, gives that same value as its mean, with no wrap.
- R7: Each block sum starts from zero. The last sample of a block counts only in that block, and the next valid sample starts the next block.
- R8: Raising reset in the middle of a block discards the partial sum. The next N valid samples form a clean block.
- R9: Between pulses, avg_data holds the last mean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | SAMPLE_W | Signed input sample |
| smp_vld | input | 1 | Input sample strobe |
| avg_data | output | SAMPLE_W | Signed block mean |
| avg_vld | output | 1 | One-cycle pulse when avg_data is new |

## Verification
A block counter that is off by one shows at the ports within one block: the pulse arrives a sample early or late, and the mean absorbs one sample from the neighbouring block. An accumulator that is not cleared at a block boundary shows in the second mean, which then carries the whole previous sum. Wrong sign handling in the shift shows only for negative sums that are not exact multiples of N, so the bench includes a block summing to -1. Invalid cycles carry full-scale garbage data, so any leak into the sum moves the very next mean by a large amount.

// File: rtl/blk_avg_decim.sv
module blk_avg_decim #(
  parameter int SAMPLE_W = 16,
  parameter int LOG2_N   = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  input  logic                       smp_vld,
  output logic signed [SAMPLE_W-1:0] avg_data,
  output logic                       avg_vld
);
  localparam int ACC_W = SAMPLE_W + LOG2_N;

  logic        [LOG2_N-1:0] cnt;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  smp_ext;
  logic signed [ACC_W-1:0]  acc_base;
  logic signed [ACC_W-1:0]  acc_nxt;
  logic                     blk_end;

  assign smp_ext  = {{LOG2_N{smp_data[SAMPLE_W-1]}}, smp_data};
  assign acc_base = (cnt == '0) ? '0 : acc;
  assign acc_nxt  = acc_base + smp_ext;
  assign blk_end  = smp_vld && (&cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      acc      <= '0;
      avg_data <= '0;
      avg_vld  <= 1'b0;
    end else begin
      avg_vld <= blk_end;
      if (smp_vld) begin
        cnt <= cnt + 1'b1;
        acc <= acc_nxt;
      end
      if (blk_end)
        avg_data <= acc_nxt[ACC_W-1:LOG2_N];
    end
  end
endmodule

// File: rtl/blk_avg_decim_chk.sv
module blk_avg_decim_chk #(
  parameter int SAMPLE_W = 16,
  parameter int LOG2_N   = 11
) (
  input logic                clk,
  input logic                rst,
  input logic                smp_vld,
  input logic [SAMPLE_W-1:0] avg_data,
  input logic                avg_vld,
  input logic [LOG2_N-1:0]   cnt
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !avg_vld);

  assert_pulse_needs_sample_R2: assert property (@(posedge clk) disable iff (rst)
    avg_vld |-> $past(smp_vld));

  assert_pulse_at_boundary_R2: assert property (@(posedge clk) disable iff (rst)
    avg_vld |-> (cnt == '0));

  assert_idle_no_count_R4: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> $stable(cnt));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    avg_vld |=> !avg_vld);

  assert_mean_held_R9: assert property (@(posedge clk) disable iff (rst)
    !avg_vld |-> $stable(avg_data));
endmodule

bind blk_avg_decim blk_avg_decim_chk #(.SAMPLE_W(SAMPLE_W), .LOG2_N(LOG2_N)) u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .avg_data(avg_data),
  .avg_vld(avg_vld), .cnt(cnt)
);

// File: tb/blk_avg_decim_bench.sv
`timescale 1ns/1ps
module blk_avg_decim_bench;
  localparam int SW  = 12;
  localparam int LN  = 4;
  localparam int N   = 1 << LN;
  localparam int MAXV = (1 << (SW-1)) - 1;
  localparam int MINV = -(1 << (SW-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [SW-1:0] smp_data = '0;
  logic smp_vld = 1'b0;
  logic signed [SW-1:0] avg_data;
  logic avg_vld;

  always #2.5 clk = ~clk;

  blk_avg_decim #(.SAMPLE_W(SW), .LOG2_N(LN)) u_blk_avg_decim (
    .clk(clk), .rst(rst), .smp_data(smp_data), .smp_vld(smp_vld),
    .avg_data(avg_data), .avg_vld(avg_vld)
  );

  int     checks = 0;
  int     fails  = 0;
  longint cyc = 0;
  longint pulse_at = -1;
  longint m_sum = 0;
  int     m_cnt = 0;
  int     expq[$];
  bit     done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic send(input int v, input bit vld);
    @(negedge clk);
    smp_data = SW'(v);
    smp_vld  = vld;
    if (vld) begin
      m_sum += longint'($signed(SW'(v)));
      m_cnt++;
      if (m_cnt == N) begin
        expq.push_back(int'(m_sum >>> LN));
        pulse_at = cyc + 1;
        m_sum = 0;
        m_cnt = 0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(MAXV, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    smp_vld = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_sum = 0;
    m_cnt = 0;
    pulse_at = -1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      bit ep;
      ep = (cyc == pulse_at);
      if (avg_vld || ep) chk("R5 pulse timing", int'(avg_vld), int'(ep));
      if (avg_vld) begin
        if (expq.size() == 0) chk("R2 unexpected pulse", 1, 0);
        else chk("R3 mean value", int'(avg_data), expq.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    chk("R1 avg_vld in reset", int'(avg_vld), 0);
    chk("R1 avg_data in reset", int'(avg_data), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 avg_vld after reset", int'(avg_vld), 0);
    chk("R1 avg_data after reset", int'(avg_data), 0);

    // R2 R3: ramp 0..15, sum 120, mean floor 7
    for (int i = 0; i < N; i++) send(i, 1'b1);
    idle(3);

    // R3: sum -1 rounds to -1
    for (int i = 0; i < N; i++) send((i == 5) ? -1 : 0, 1'b1);
    idle(2);

    // R4: invalid cycles carry full-scale garbage
    for (int i = 0; i < N; i++) begin
      send(MINV, 1'b0);
      send(3 * i - 20, 1'b1);
    end
    idle(2);

    // R6: full scale both ways, back to back (R7)
    for (int i = 0; i < N; i++) send(MAXV, 1'b1);
    for (int i = 0; i < N; i++) send(MINV, 1'b1);
    for (int i = 0; i < N; i++) send(100, 1'b1);
    for (int i = 0; i < N; i++) send(-50, 1'b1);
    idle(2);

    // R9: mean holds during idle
    held = int'(avg_data);
    idle(6);
    chk("R9 hold", int'(avg_data), held);
    chk("R9 hold value", held, -50);

    // R8: reset mid-block
    for (int i = 0; i < 7; i++) send(1000, 1'b1);
    do_reset();
    chk("R8 no pulse after reset", int'(avg_vld), 0);
    for (int i = 0; i < N; i++) send(5, 1'b1);
    idle(2);

    // R3 R7: pseudo-random blocks with sporadic gaps
    for (int i = 0; i < 3 * N + 10; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(int'($signed(lfsr[SW-1:0])), lfsr[3] | lfsr[7]);
    end
    while (m_cnt != 0) send(-7, 1'b1);
    idle(3);

    chk("R2 all means delivered", expq.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule